// File: doc/BRIEF.md
# Contiguous Command Slot Allocator

The allocator hands out runs of consecutive command slots from a pool that is split into equal sets. A requester asks for N slots. The block finds the lowest free run of N slots that fits inside a single set. It marks those slots as taken and returns the set number and the first slot inside that set. If no set can hold the run, it reports a miss instead. A single invalidate pulse returns every slot to the pool.

A bitmap holds occupancy for the whole pool. The search moves set by set, from low to high, and tests one candidate start each cycle. When a candidate run would spill past the end of its set, the rest of that set is skipped and the search goes on at slot 0 of the next set. The reported set number includes a fixed base offset, so that several pools can share one numbering space. Writing the commands into the granted slots is left to other logic.

Top module: `cmd_slot_alloc`

## Requirements
- R1: After reset, req_ready_o is 1, done_o is 0 and ok_o is 0, and every slot is free.
- R2: A request whose length is 0 or greater than SLOTS_PER_SET is refused. done_o=1 with ok_o=0 appears in the cycle right after the request is accepted, and no slot is consumed.
- R3: The grant goes to the lowest start position whose run of N free slots lies inside one set. Sets are scanned in increasing order, and slots in increasing order within a set.
- R4: A granted run never crosses a set boundary. A candidate that would cross one causes the search to resume at slot 0 of the next set.
- R5: On a grant, done_o and ok_o are both 1 for one cycle. set_o equals BASE_SET plus the set index, and slot_o is the offset of the first granted slot inside that set.
- R6: Granted slots stay occupied and are never granted again until an invalidate.
- R7: When no set can hold the run, done_o=1 with ok_o=0 is reported and the occupancy is left unchanged.
- R8: A pulse on inv_i frees every slot. On an already empty pool it has no visible effect.
- R9: req_ready_o is 0 from the cycle after a valid-length request is accepted until the cycle in which its result is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Allocator idle and able to accept a request |
| req_len_i | input | LEN_W | Number of consecutive slots requested |
| inv_i | input | 1 | Free all slots |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | 1 = grant, 0 = refused or no room (valid while done_o) |
| set_o | output | SET_O_W | Granted set number including BASE_SET |
| slot_o | output | OFF_W | First granted slot inside the set |

## Verification
The assertions check on every cycle that a grant never crosses a set boundary, that the reported set lies in range, that a commit never touches an occupied slot and leaves its slots set, that an invalidate empties the map, that bad lengths are refused one cycle later, and that the block goes busy after a valid request is accepted. Only the bench scenarios can show first-fit ordering. This includes a run that is skipped at a set end followed by a later short run that goes back into the lower set. The same applies to correct no-room reporting on a fragmented pool, to the occupancy surviving a miss, and to the pool being fully reusable after an invalidate.

// File: rtl/cmd_slot_alloc_pkg.sv
package cmd_slot_alloc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/slot_window_mask.sv
module slot_window_mask #(
  parameter int unsigned TOTAL = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned LEN_W = 4
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [TOTAL-1:0] mask_o
);
  logic [IDX_W:0] end_w;
  assign end_w = {1'b0, start_i} + (IDX_W+1)'(len_i);

  for (genvar k = 0; k < TOTAL; k++) begin : g_bit
    assign mask_o[k] = ((IDX_W+1)'(k) >= {1'b0, start_i}) && ((IDX_W+1)'(k) < end_w);
  end
endmodule

// File: rtl/slot_occupancy.sv
module slot_occupancy #(
  parameter int unsigned TOTAL = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOTAL-1:0] mask_i,
  input  logic             commit_i,
  input  logic             clr_i,
  output logic [TOTAL-1:0] occ_o
);
  logic [TOTAL-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       occ_q <= '0;
    else if (clr_i)    occ_q <= '0;   // invalidate wins over a coincident commit
    else if (commit_i) occ_q <= occ_q | mask_i;
  end

  assign occ_o = occ_q;

  assert_no_double_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> ((occ_q & mask_i) == '0));

  assert_grant_marked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !clr_i) |=> ((occ_q & $past(mask_i)) == $past(mask_i)));

  assert_inv_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (occ_q == '0));
endmodule

// File: rtl/slot_scan_ctrl.sv
module slot_scan_ctrl
  import cmd_slot_alloc_pkg::*;
#(
  parameter int unsigned NUM_SETS      = 4,
  parameter int unsigned SLOTS_PER_SET = 8,
  parameter int unsigned BASE_SET      = 0,
  parameter int unsigned LEN_W         = 4,
  parameter int unsigned OFF_W         = 3,
  parameter int unsigned IDX_W         = 6,
  parameter int unsigned SET_O_W       = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LEN_W-1:0]   req_len_i,
  output logic               req_ready_o,
  input  logic               win_busy_i,
  output logic [IDX_W-1:0]   start_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               commit_o,
  output logic               done_o,
  output logic               ok_o,
  output logic [SET_O_W-1:0] set_o,
  output logic [OFF_W-1:0]   slot_o
);
  localparam int unsigned SET_CNT_W = $clog2(NUM_SETS + 1);

  scan_state_e          state_q;
  logic [SET_CNT_W-1:0] set_q;
  logic [OFF_W-1:0]     off_q;
  logic [LEN_W-1:0]     len_q;
  logic                 done_q, ok_q;
  logic [SET_O_W-1:0]   rset_q;
  logic [OFF_W-1:0]     rslot_q;

  logic accept, len_bad, pool_end, crosses, fits;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign len_bad     = (req_len_i == '0) || (int'(req_len_i) > SLOTS_PER_SET);
  assign pool_end    = (int'(set_q) >= NUM_SETS);
  assign crosses     = (int'(off_q) + int'(len_q)) > SLOTS_PER_SET;
  assign fits        = (state_q == ST_SCAN) && !pool_end && !crosses && !win_busy_i;
  assign commit_o    = fits;
  assign start_o     = IDX_W'(int'(set_q) * SLOTS_PER_SET + int'(off_q));
  assign len_o       = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set_q   <= '0;
      off_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      rset_q  <= '0;
      rslot_q <= '0;
    end else begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            len_q <= req_len_i;
            set_q <= '0;
            off_q <= '0;
            if (len_bad) done_q <= 1'b1;
            else         state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (pool_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (crosses) begin
            // candidate would spill into the next set: jump to its first slot
            set_q <= set_q + 1'b1;
            off_q <= '0;
          end else if (!win_busy_i) begin
            done_q  <= 1'b1;
            ok_q    <= 1'b1;
            rset_q  <= SET_O_W'(set_q) + SET_O_W'(BASE_SET);
            rslot_q <= off_q;
            state_q <= ST_IDLE;
          end else if (int'(off_q) == SLOTS_PER_SET - 1) begin
            set_q <= set_q + 1'b1;
            off_q <= '0;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign set_o  = rset_q;
  assign slot_o = rslot_q;

  assert_bad_len_refused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && ((req_len_i == '0) || (int'(req_len_i) > SLOTS_PER_SET)))
      |=> (done_o && !ok_o));

  assert_no_straddle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> ((int'(slot_o) + int'(len_q)) <= SLOTS_PER_SET));

  assert_set_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> ((int'(set_o) >= BASE_SET) && (int'(set_o) < BASE_SET + NUM_SETS)));

  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_len_i != '0) && (int'(req_len_i) <= SLOTS_PER_SET))
      |=> !req_ready_o);
endmodule

// File: rtl/cmd_slot_alloc.sv
module cmd_slot_alloc #(
  parameter int unsigned NUM_SETS      = 4,
  parameter int unsigned SLOTS_PER_SET = 8,
  parameter int unsigned BASE_SET      = 0,
  localparam int unsigned TOTAL   = NUM_SETS * SLOTS_PER_SET,
  localparam int unsigned LEN_W   = $clog2(SLOTS_PER_SET + 1),
  localparam int unsigned OFF_W   = (SLOTS_PER_SET > 1) ? $clog2(SLOTS_PER_SET) : 1,
  localparam int unsigned IDX_W   = $clog2(TOTAL + 1),
  localparam int unsigned SET_O_W = ((BASE_SET + NUM_SETS) > 1) ? $clog2(BASE_SET + NUM_SETS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic               inv_i,
  output logic               done_o,
  output logic               ok_o,
  output logic [SET_O_W-1:0] set_o,
  output logic [OFF_W-1:0]   slot_o
);
  logic [IDX_W-1:0] start_w;
  logic [LEN_W-1:0] len_w;
  logic [TOTAL-1:0] mask_w, occ_w;
  logic             commit_w, busy_w;

  assign busy_w = |(occ_w & mask_w);

  slot_window_mask #(.TOTAL(TOTAL), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_mask (
    .start_i (start_w),
    .len_i   (len_w),
    .mask_o  (mask_w)
  );

  slot_occupancy #(.TOTAL(TOTAL)) u_occ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_i   (mask_w),
    .commit_i (commit_w),
    .clr_i    (inv_i),
    .occ_o    (occ_w)
  );

  slot_scan_ctrl #(
    .NUM_SETS(NUM_SETS), .SLOTS_PER_SET(SLOTS_PER_SET), .BASE_SET(BASE_SET),
    .LEN_W(LEN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .SET_O_W(SET_O_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_len_i   (req_len_i),
    .req_ready_o (req_ready_o),
    .win_busy_i  (busy_w),
    .start_o     (start_w),
    .len_o       (len_w),
    .commit_o    (commit_w),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .set_o       (set_o),
    .slot_o      (slot_o)
  );
endmodule

// File: tb/sim_cmd_slot_alloc.sv
module sim_cmd_slot_alloc;
  localparam int unsigned NS = 4, SPS = 8, BASE = 2;
  localparam int unsigned LEN_W = $clog2(SPS + 1);
  localparam int unsigned OFF_W = $clog2(SPS);
  localparam int unsigned SET_O_W = $clog2(BASE + NS);
  localparam int NV = 11;
  // per row: length, expected ok, expected set, expected slot, requirement tag index
  localparam int V_LEN [NV] = '{5, 4, 3, 8, 4, 9, 0, 6, 3, 2, 1};
  localparam int V_OK  [NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 0, 1, 0};
  localparam int V_SET [NV] = '{2, 3, 2, 4, 3, 0, 0, 5, 0, 5, 0};
  localparam int V_SLOT[NV] = '{0, 0, 5, 0, 4, 0, 0, 0, 0, 6, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, inv = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, done, ok;
  logic [SET_O_W-1:0] set_w;
  logic [OFF_W-1:0] slot_w;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cmd_slot_alloc #(.NUM_SETS(NS), .SLOTS_PER_SET(SPS), .BASE_SET(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_len_i(req_len), .inv_i(inv), .done_o(done), .ok_o(ok),
    .set_o(set_w), .slot_o(slot_w)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic alloc(input int len, input int e_ok, input int e_set, input int e_slot, input string tag);
    int waited = 0;
    bit bad = (len == 0) || (len > SPS);
    @(negedge clk);
    check({tag, " ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1;
    req_len   = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) check("R2 refusal one cycle after accept", int'(done), 1);
    while (!done && waited < 200) begin
      if (req_ready) check("R9 ready low while searching", int'(req_ready), 0);
      @(negedge clk);
      waited++;
    end
    check({tag, " done seen"}, int'(done), 1);
    check({tag, " ok"}, int'(ok), e_ok);
    if (e_ok == 1) begin
      check({tag, " set"}, int'(set_w), e_set);
      check({tag, " slot"}, int'(slot_w), e_slot);
    end
    @(negedge clk);
    check("R5 done is a single-cycle strobe", int'(done), 0);
  endtask

  task automatic invalidate();
    @(negedge clk);
    inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 done after reset", int'(done), 0);
    check("R1 ok after reset", int'(ok), 0);

    // R8: invalidate on an empty pool changes nothing visible
    invalidate();
    alloc(SPS, 1, BASE, 0, "R1 R8 full set on fresh pool");
    invalidate();

    // table walk: first-fit, set skipping, refusals, no-room, fill-up
    for (int i = 0; i < NV; i++) begin
      string tg;
      if (V_LEN[i] == 0 || V_LEN[i] > SPS) tg = "R2";
      else if (V_OK[i] == 0)              tg = "R7";
      else if (i == 2 || i == 9)          tg = "R3";
      else if (i == 1 || i == 7)          tg = "R4";
      else                                tg = "R5 R6";
      alloc(V_LEN[i], V_OK[i], V_SET[i], V_SLOT[i], tg);
    end

    // R8: everything free again after an invalidate
    invalidate();
    alloc(SPS, 1, BASE, 0, "R8 set 0 reusable");
    alloc(SPS, 1, BASE + 1, 0, "R8 set 1 reusable");
    invalidate();

    // R4 then R3: a run skipped at the end of a set, a later short run goes back
    alloc(6, 1, BASE, 0, "R3 low start");
    alloc(3, 1, BASE + 1, 0, "R4 skip crossing run");
    alloc(2, 1, BASE, 6, "R3 tail of lower set");
    alloc(1, 1, BASE + 1, 3, "R6 next free after grants");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule